// File: doc/BRIEF.md
# Transport Packet Energy Dispersal Scrambler

This block whitens a byte stream of 188-byte transport packets before it reaches the transmission coder. Each payload byte is XORed with eight bits from a 15-stage pseudo-random generator, so long runs of identical bits in the payload no longer show up as spectral lines on the channel. Sync bytes are never scrambled. They carry the framing for the receiver's descrambler instead.

Packets are counted in groups of eight. On the sync byte of the first packet in a group, the generator is reloaded with a fixed seed and that sync byte is sent bit-inverted. The receiver uses the inverted sync byte to find the reload point. The other seven sync bytes pass through unchanged. The generator keeps advancing during them, but its output is thrown away. A disable input turns scrambling off without changing the framing.

The output is registered, one clock after the input. Valid and start-of-packet travel through the same register as the data.

Top module: `ts_dispersal`

## Requirements
- R1: `out_valid` and `out_sop` equal `in_valid` and `in_valid && in_sop` of the previous clock.
- R2: For a valid non-sync byte with `bypass` low, `out_data` is `in_data` XOR the next eight generator bits.
  - The first of those bits goes to bit 7.
  - On each step, the generator's output bit is stage 14 XOR stage 15.
  - That bit is shifted into stage 1, while stages 1 to 14 move up by one.
- R3: On the sync byte of the first packet of a group, stages 1 to 15 are loaded with 1,0,0,1,0,1,0,1,0,0,0,0,0,0,0. The next payload byte uses the first eight bits generated from that seed.
- R4: The sync byte of the first packet of a group is output bit-inverted, so 0x47 becomes 0xB8.
- R5: The sync bytes of packets two to eight of a group are output unchanged. The generator advances eight steps during each of them.
- R6: With `bypass` high, non-sync bytes pass unchanged, and the generator still advances eight steps per byte. Sync handling stays as in R4 and R5.
- R7: While `rst` is high, `out_valid` and `out_sop` are low one clock later. The first start-of-packet after reset is treated as the first packet of a group.
- R8: A clock with `in_valid` low advances neither the generator nor the packet count, and `out_valid` is low on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_sop | input | 1 | Input byte is a sync byte (first byte of a packet) |
| in_data | input | 8 | Input byte |
| bypass | input | 1 | Disable scrambling of non-sync bytes |
| out_valid | output | 1 | Output byte is valid |
| out_sop | output | 1 | Output byte is a sync byte |
| out_data | output | 8 | Scrambled byte |

## Verification
A generator state that is off by even one step corrupts every later payload byte. The error therefore shows at `out_data` on the first valid non-sync byte after the fault, and only a reload at the next group start clears it. A wrong packet count shows up as the inverted sync byte in the wrong packet, at that packet's first byte. It also moves the reload point, so every payload byte from there on is wrong. The reference model steps its own 15-stage register one bit at a time and compares every output clock. Bypass windows check that the generator keeps advancing: once bypass drops, the scrambled bytes must pick up at the right point in the sequence.

// File: rtl/ts_dispersal.sv
module ts_dispersal #(
  parameter int            GROUP_PKTS = 8,
  parameter int            LEN        = 15,
  parameter logic [LEN-1:0] SEED      = 15'h00A9,
  parameter int            TAP_A      = 14,
  parameter int            TAP_B      = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic [7:0] in_data,
  input  logic       bypass,
  output logic       out_valid,
  output logic       out_sop,
  output logic [7:0] out_data
);
  localparam int CW = (GROUP_PKTS > 1) ? $clog2(GROUP_PKTS) : 1;

  logic [CW-1:0]  grp;
  logic [LEN-1:0] lfsr, lfsr_adv;
  logic [7:0]     prbs;
  logic           first_sync;

  assign first_sync = in_valid && in_sop && (grp == '0);

  always_comb begin
    lfsr_adv = lfsr;
    prbs     = '0;
    for (int k = 0; k < 8; k++) begin
      prbs[7-k] = lfsr_adv[TAP_A-1] ^ lfsr_adv[TAP_B-1];
      lfsr_adv  = {lfsr_adv[LEN-2:0], prbs[7-k]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp       <= '0;
      lfsr      <= SEED;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sop   <= in_valid && in_sop;
      if (in_valid) begin
        if (in_sop)
          grp <= (grp == CW'(GROUP_PKTS - 1)) ? '0 : grp + 1'b1;
        lfsr <= first_sync ? SEED : lfsr_adv;
        if (in_sop)
          out_data <= first_sync ? ~in_data : in_data;
        else
          out_data <= bypass ? in_data : (in_data ^ prbs);
      end
    end
  end
endmodule

// File: rtl/ts_dispersal_chk.sv
module ts_dispersal_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_sop,
  input logic [7:0] in_data,
  input logic       bypass,
  input logic       out_valid,
  input logic       out_sop,
  input logic [7:0] out_data
);
  logic [2:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (in_valid && in_sop) seen <= seen + 1'b1;
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R8
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R1
  sop_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop) |=> out_sop);
  // R4
  first_sync_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop && seen == 3'd0) |=> out_data == ~$past(in_data));
  // R5
  later_sync_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop && seen != 3'd0) |=> out_data == $past(in_data));
  // R6
  bypass_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sop && bypass) |=> out_data == $past(in_data));
  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_sop));
endmodule

bind ts_dispersal ts_dispersal_chk i_chk (.*);

// File: tb/test_ts_dispersal.sv
module test_ts_dispersal;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sop = 1'b0, bypass = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid, out_sop;
  logic [7:0] out_data;

  int tests = 0, fails = 0;

  logic       m_lf [1:15];
  int         m_pkt;
  logic       e_valid, e_sop;
  logic [7:0] e_data;
  string      e_tag;

  always #5 clk = ~clk;

  ts_dispersal i_ts_dispersal (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .bypass(bypass),
    .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic seed_model();
    logic [15:1] s = 15'b000000010101001;
    for (int i = 1; i <= 15; i++) m_lf[i] = s[i];
  endtask

  function automatic logic [7:0] gen_byte();
    logic [7:0] b = '0;
    for (int k = 0; k < 8; k++) begin
      logic fb = m_lf[14] ^ m_lf[15];
      for (int i = 15; i >= 2; i--) m_lf[i] = m_lf[i-1];
      m_lf[1] = fb;
      b = {b[6:0], fb};
    end
    return b;
  endfunction

  task automatic step(logic v, logic s, logic [7:0] d, logic b);
    logic [7:0] p;
    in_valid = v; in_sop = s; in_data = d; bypass = b;
    e_valid = v; e_sop = v && s;
    if (!v) e_tag = "R8";
    else if (s) begin
      if (m_pkt % 8 == 0) begin
        seed_model(); e_data = ~d; e_tag = "R4";
      end else begin
        p = gen_byte(); e_data = d; e_tag = "R5";
      end
      m_pkt++;
    end else begin
      p = gen_byte();
      e_data = b ? d : (d ^ p);
      e_tag = b ? "R6" : ((m_pkt % 8 == 1) ? "R3" : "R2");
    end
    @(negedge clk);
    check("R1 valid", {7'd0, out_valid}, {7'd0, e_valid});
    check("R1 sop", {7'd0, out_sop}, {7'd0, e_sop});
    if (e_valid) check({e_tag, " data"}, out_data, e_data);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R7 valid low", {7'd0, out_valid}, 8'd0);
    check("R7 sop low", {7'd0, out_sop}, 8'd0);
    rst = 1'b0; m_pkt = 0; seed_model();
  endtask

  task automatic run_packets(int n, int pat, int byp_pkt);
    for (int p = 0; p < n; p++) begin
      for (int b = 0; b < 188; b++) begin
        logic [7:0] d;
        logic       by;
        if (b % 7 == 3) step(1'b0, 1'b0, 8'h5A, 1'b0);
        case (pat)
          0: d = 8'h00;
          1: d = 8'hFF;
          default: d = 8'(b * 3 + p);
        endcase
        if (b == 0) d = 8'h47;
        by = (p == byp_pkt) && (b >= 20) && (b < 60);
        step(1'b1, b == 0, d, by);
      end
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_pkt = 0;
    @(negedge clk);
    do_reset();
    run_packets(3, 0, 1);
    run_packets(3, 1, -1);
    run_packets(4, 2, 6);
    run_packets(2, 2, 0);
    do_reset();
    run_packets(2, 0, -1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule